// File: doc/BRIEF.md
# Register Ready-Bit Interlock

This block guards the decode stage of an in-order pipeline. It holds one ready bit per architectural register. A bit reads 1 when no instruction in flight still owes a result to that register. When an instruction leaves decode and names a destination, that destination's bit drops. When the result for a register comes back on the writeback port, its bit rises again.

Each cycle the block takes the register fields of the instruction sitting in decode, together with a use flag for each field. It raises `stall` if any field in use names a register whose bit is low. The destination is checked as well as the sources. An instruction therefore waits behind an older writer of the same register, not only behind the producer of a value it reads. This costs one flop per register, and the price is stalls that a finer scheme would avoid.

Issue happens in a cycle where `dec_vld` is high and `stall` is low. Only in that cycle does the destination bit drop. Register 0 is hard-wired: it always reads ready and is never cleared.

Top module: `reg_ready_interlock`

## Requirements
- R1: After reset every ready bit is 1 and `stall` is 0.
- R2: An instruction issues when `dec_vld`=1 and `stall`=0. On the next edge, issue with `dec_dst_use`=1 clears bit `dec_dst_idx` of `ready_vec`. A stalled instruction changes no bit.
- R3: `wb_en`=1 sets bit `wb_idx` of `ready_vec` on the next edge.
- R4: If an issue clears a register and a writeback sets the same register in one cycle, the bit is 0 afterwards.
- R5: `stall` is 1 when `dec_vld`=1 and some source i has `dec_src_use[i]`=1 while its register reads 0. Source i sits in `dec_src_idx[i*IDX_W +: IDX_W]`.
- R6: `stall` is 1 when `dec_vld`=1, `dec_dst_use`=1 and the destination reads 0, even if all sources are ready.
- R7: A field whose use flag is 0 never causes a stall.
- R8: Register 0 always reads 1. Issuing with destination 0 leaves it 1, and fields naming register 0 never stall.
- R9: `stall` is 0 whenever `dec_vld` is 0.
- R10: The check uses the bits held at the start of the cycle. A writeback in the same cycle as the check releases the stall only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_vld | input | 1 | Decode holds an instruction that wants to issue |
| dec_src_idx | input | NUM_SRC*IDX_W | Source register numbers, packed, source i at [i*IDX_W +: IDX_W] |
| dec_src_use | input | NUM_SRC | Per-source use flags |
| dec_dst_idx | input | IDX_W | Destination register number |
| dec_dst_use | input | 1 | Destination use flag |
| wb_en | input | 1 | A result is written back this cycle |
| wb_idx | input | IDX_W | Register being written back |
| stall | output | 1 | Decode must hold its instruction |
| ready_vec | output | NUM_REGS | Ready bit of every register |

## Verification
Read-after-write patterns check that a pending source stalls from either source slot. Write-after-write patterns with ready sources show that the destination is checked on its own. Toggling use flags on fields that name pending registers separates a real conflict from an unused field. Same-cycle cases cover writeback during a stall and a clear meeting a set on one register; they confirm that the check uses registered bits and that the clear wins. A burst of issues followed by staggered writebacks confirms that the bits are tracked independently per register.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int DEF_NUM_REGS = 32;
  localparam int DEF_NUM_SRC  = 2;

  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_SRC  = 2'd1,
    HZ_DST  = 2'd2,
    HZ_BOTH = 2'd3
  } hz_kind_e;

  function automatic hz_kind_e classify(input logic src_blk, input logic dst_blk);
    return hz_kind_e'({dst_blk, src_blk});
  endfunction
endpackage

// File: rtl/sb_ready_bits.sv
module sb_ready_bits #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  output logic [NUM_REGS-1:0] bits
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign bits[g] = 1'b1;
    end else begin : g_flop
      logic hit_clr, hit_set;
      assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
      assign hit_set = set_en && (set_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bits[g] <= 1'b1;
        else if (hit_clr) bits[g] <= 1'b0;
        else if (hit_set) bits[g] <= 1'b1;
      end
    end
  end

  // R2
  one_drop_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bits) + 1) >= $past($countones(bits)));
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]      bits,
  input  logic                     vld,
  input  logic [NUM_SRC*IDX_W-1:0] src_idx,
  input  logic [NUM_SRC-1:0]       src_use,
  input  logic [IDX_W-1:0]         dst_idx,
  input  logic                     dst_use,
  output logic                     stall,
  output hz_kind_e                 kind
);
  logic [NUM_SRC-1:0] src_blk;
  logic               dst_blk;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_blk[i] = src_use[i] && !bits[src_idx[i*IDX_W +: IDX_W]];
  end
  assign dst_blk = dst_use && !bits[dst_idx];

  assign kind  = vld ? classify(|src_blk, dst_blk) : HZ_NONE;
  assign stall = (kind != HZ_NONE);

  // R9
  always_comb begin
    idle_no_stall_chk: assert (vld || !stall);
  end
endmodule

// File: rtl/reg_ready_interlock.sv
module reg_ready_interlock
  import sb_pkg::*;
#(
  parameter int NUM_REGS = sb_pkg::DEF_NUM_REGS,
  parameter int NUM_SRC  = sb_pkg::DEF_NUM_SRC,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_vld,
  input  logic [NUM_SRC*IDX_W-1:0] dec_src_idx,
  input  logic [NUM_SRC-1:0]       dec_src_use,
  input  logic [IDX_W-1:0]         dec_dst_idx,
  input  logic                     dec_dst_use,
  input  logic                     wb_en,
  input  logic [IDX_W-1:0]         wb_idx,
  output logic                     stall,
  output logic [NUM_REGS-1:0]      ready_vec
);
  hz_kind_e hz_kind;
  logic     iss_fire;
  logic     clr_en;
  logic     wb_only;

  assign iss_fire = dec_vld && !stall;
  assign clr_en   = iss_fire && dec_dst_use && (dec_dst_idx != '0);
  assign wb_only  = wb_en && (wb_idx != '0) && !(clr_en && dec_dst_idx == wb_idx);

  sb_ready_bits #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_en),
    .clr_idx (dec_dst_idx),
    .set_en  (wb_en),
    .set_idx (wb_idx),
    .bits    (ready_vec)
  );

  sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_hz (
    .bits    (ready_vec),
    .vld     (dec_vld),
    .src_idx (dec_src_idx),
    .src_use (dec_src_use),
    .dst_idx (dec_dst_idx),
    .dst_use (dec_dst_use),
    .stall   (stall),
    .kind    (hz_kind)
  );

  // R2
  issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !ready_vec[$past(dec_dst_idx)]);

  // R3
  wb_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_only |=> ready_vec[$past(wb_idx)]);

  // R2
  stalled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !wb_en) |=> $stable(ready_vec));

  // R8
  zero_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> ready_vec[0]);
endmodule

// File: tb/test_reg_ready_interlock.sv
module test_reg_ready_interlock;
  localparam int NR = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dec_vld = 1'b0;
  logic [2*IW-1:0] dec_src_idx = '0;
  logic [1:0]    dec_src_use = '0;
  logic [IW-1:0] dec_dst_idx = '0;
  logic          dec_dst_use = 1'b0;
  logic          wb_en = 1'b0;
  logic [IW-1:0] wb_idx = '0;
  logic          stall;
  logic [NR-1:0] ready_vec;

  int checks = 0;
  int errors = 0;
  logic [NR-1:0] model = '1;
  bit            exp_stall_q[$];
  logic [NR-1:0] exp_vec_q[$];
  string         tag_q[$];
  event          sample_ev;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  reg_ready_interlock i_reg_ready_interlock (
    .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_src_idx(dec_src_idx),
    .dec_src_use(dec_src_use), .dec_dst_idx(dec_dst_idx), .dec_dst_use(dec_dst_use),
    .wb_en(wb_en), .wb_idx(wb_idx), .stall(stall), .ready_vec(ready_vec)
  );

  task automatic step(input bit v, input int s0, input bit u0, input int s1, input bit u1,
                      input int d, input bit du, input bit we, input int wi, input string tag);
    bit es;
    @(negedge clk);
    dec_vld = v; dec_src_idx = {IW'(s1), IW'(s0)}; dec_src_use = {u1, u0};
    dec_dst_idx = IW'(d); dec_dst_use = du; wb_en = we; wb_idx = IW'(wi);
    es = v && ((u0 && !model[s0]) || (u1 && !model[s1]) || (du && !model[d]));
    exp_stall_q.push_back(es);
    exp_vec_q.push_back(model);
    tag_q.push_back(tag);
    -> sample_ev;
    if (we) model[wi] = 1'b1;
    if (v && !es && du && d != 0) model[d] = 1'b0;
    model[0] = 1'b1;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      #1;
      begin
        bit es; logic [NR-1:0] ev; string t;
        es = exp_stall_q.pop_front(); ev = exp_vec_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (stall !== es) begin
          errors++;
          $display("FAIL %s stall actual %0b expected %0b", t, stall, es);
        end
        checks++;
        if (ready_vec !== ev) begin
          errors++;
          $display("FAIL %s ready_vec actual %h expected %h", t, ready_vec, ev);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    // R2 issue writes r5
    step(1, 1, 1, 2, 1, 5, 1, 0, 0, "R2 issue no stall");
    idle("R2 r5 cleared");
    // R5 read pending r5 from each source slot
    step(1, 5, 1, 3, 1, 6, 1, 0, 0, "R5 src0 raw");
    step(1, 3, 1, 5, 1, 6, 1, 0, 0, "R5 src1 raw");
    // R7 unused fields naming r5
    step(1, 3, 1, 5, 0, 7, 1, 0, 0, "R7 unused src issues");
    step(1, 2, 1, 3, 1, 5, 0, 0, 0, "R7 unused dst issues");
    // R6 waw: dst r5 pending, sources ready
    step(1, 1, 1, 2, 1, 5, 1, 0, 0, "R6 waw stall");
    // R2 stalled instruction must not clear r8
    step(1, 5, 1, 0, 0, 8, 1, 0, 0, "R2 stalled no clear");
    idle("R2 r8 still ready");
    // R10 writeback during stall releases only next cycle
    step(1, 5, 1, 0, 0, 8, 1, 1, 5, "R10 wb same cycle still stalls");
    step(1, 5, 1, 0, 0, 8, 1, 0, 0, "R3 r5 set, issue proceeds");
    // R4 clear and set of r9 in one cycle
    step(1, 1, 1, 2, 1, 9, 1, 1, 9, "R4 clear beats set");
    idle("R4 r9 cleared");
    // R8 register 0
    step(1, 0, 1, 0, 1, 0, 1, 0, 0, "R8 dst zero");
    idle("R8 r0 ready");
    // R9 no stall without dec_vld
    step(0, 9, 1, 8, 1, 9, 1, 0, 0, "R9 idle no stall");
    // writeback leftovers
    step(0, 0, 0, 0, 0, 0, 0, 1, 8, "R3 wb r8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 9, "R3 wb r9");
    step(0, 0, 0, 0, 0, 0, 0, 1, 6, "R3 wb r6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 7, "R3 wb r7");
    idle("R3 all ready");
    // burst of writers then staggered writebacks
    for (int k = 10; k < 15; k++) step(1, k - 10, 1, 31, 1, k, 1, 0, 0, "R2 burst issue");
    for (int k = 10; k < 15; k++) begin
      step(1, k, 1, 31, 0, 20, 1, 0, 0, "R5 burst pending read");
      step(0, 0, 0, 0, 0, 0, 0, 1, k, "R3 burst wb");
    end
    step(1, 14, 1, 13, 1, 20, 1, 0, 0, "R5 burst released");
    idle("R2 final");
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule